// File: doc/BRIEF.md
# Serial EEPROM Slave Front End with Hold

This block is the bus-facing half of a byte-organized serial memory model. A fast system clock samples the serial clock, the active-low select, the data input, the active-low pause input and the active-low status-protect input, all already synchronized by the caller. From these it recovers the serial edges, decodes an opcode, a 16-bit address and data, and serves reads from and single-byte writes to an internal byte array. The serial output comes out as a data bit plus an output-enable, which the pad ring turns into a three-state pin.

The clock may idle low or high: input bits are taken on the rising serial edge and the output changes on the falling serial edge. A pause input freezes a transfer at its current bit so that the master can service something else, and a select pulse carrying no clocks throws away any half-finished sequence. Writes reach the array only when select is released on a byte boundary. The block then reports busy for a set number of system clocks.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the output enable is low, the status byte reads 0x00 and every array byte reads 0xFF.
- R2: While select is high the output enable is low and serial clocks and input bits have no effect.
- R3: Transfers work with the serial clock idling low (mode 0) and idling high (mode 3). Bits are taken on the rising edge and the output changes on the falling edge, most significant bit first.
- R4: Opcode 0x03 followed by a 16-bit address (high byte first) streams array bytes. The address advances after each byte and wraps from DEPTH-1 to 0 until select rises.
- R5: Opcode 0x06 sets the write-enable flag and 0x04 clears it. Opcode 0x05 streams the status byte: bit 7 status-protect enable, bits 3:2 block bits, bit 1 write-enable flag, bit 0 busy, other bits zero.
- R6: Opcode 0x02 with address and data writes the first data byte only when select rises with no partial byte pending and the write-enable flag is set. The flag then clears.
- R7: After a commit, busy reads 1 for BUSY_CYCLES system clocks. While busy, every opcode other than 0x05 is ignored.
- R8: Opcode 0x01 with one data byte loads status bits 7 and 3:2 under the same commit rule as R6. It is refused, leaving the write-enable flag set, when bit 7 is already 1 and the protect input is low.
- R9: A pause begins only when the pause input is low while the serial clock is low, and ends only when it is high while the serial clock is low. During a pause the output enable is low, clocks and input bits are ignored, and the bit position is kept.
- R10: A select low-then-high pulse with no clocks abandons any partial sequence, and the next byte is decoded as an opcode.
- R11: After reset no sequence is accepted until a high-to-low select edge is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock, synchronized |
| cs_n_i | input | 1 | Active-low select, synchronized |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Active-low pause request |
| wp_n_i | input | 1 | Active-low status-protect input |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Serial data out drive enable (low means high impedance) |

## Verification
Reads are tried with the clock idling low and idling high, so that a wrong edge choice shows up as a bit shift in one mode only. Write sequences are ended cleanly, ended mid-byte and sent without the enable flag, which separates the commit rule from plain decoding. A read run across the last address shows whether the wrap lands on 0. A read paused mid-byte, with clocks and noise on the input during the pause, tells a frozen bit position from one that kept counting. The protect input and a busy window are set against status writes and opcodes, which shows that refusal and ignoring happen exactly where required.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADH,
        ST_ADL,
        ST_RDAT,
        ST_WDAT,
        ST_SRW,
        ST_SRR,
        ST_SKIP
    } eep_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic active;
        logic cs_end;
    } bus_ev_t;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRIT = 8'h02;

    function automatic logic [7:0] pack_status(input logic wpen, input logic [1:0] bp,
                                               input logic wel, input logic busy);
        return {wpen, 3'b000, bp, wel, busy};
    endfunction

endpackage

// File: rtl/eep_bus_front.sv
module eep_bus_front
    import eep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sck_i,
    input  logic    cs_n_i,
    input  logic    hold_n_i,
    output bus_ev_t ev
);
    logic sck_q, cs_q, selected, paused;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b0;
            selected <= 1'b0;
            paused   <= 1'b0;
        end else begin
            sck_q <= sck_i;
            cs_q  <= cs_n_i;
            if (cs_n_i) begin
                selected <= 1'b0;
                paused   <= 1'b0;
            end else begin
                if (cs_q) selected <= 1'b1;
                if (!sck_i) paused <= !hold_n_i;
            end
        end
    end

    always_comb begin
        ev.active = selected && !paused && !cs_n_i;
        ev.rise   = ev.active && sck_i && !sck_q;
        ev.fall   = ev.active && !sck_i && sck_q;
        ev.cs_end = selected && cs_n_i;
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int BUSY_CYCLES = 250,
    localparam int AW = $clog2(DEPTH),
    localparam int BW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic          si_i,
    input  logic          wp_n_i,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          mem_we,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          so_o,
    output logic          so_oe_o,
    output logic          busy_o
);
    eep_state_e  st;
    logic [2:0]  bitcnt;
    logic [6:0]  shin;
    logic [15:0] addr;
    logic        is_wr, out_on, wel, wpen, pend, we_q, so_q;
    logic [1:0]  bp;
    logic [7:0]  out_sr, pend_data, rx_byte, status;
    logic [15:0] adl_addr;
    logic [BW-1:0] busy_cnt;

    assign rx_byte  = {shin, si_i};
    assign adl_addr = {addr[15:8], rx_byte};
    assign busy_o   = (busy_cnt != '0);
    assign status   = pack_status(wpen, bp, wel, busy_o);
    assign rd_addr  = (st == ST_ADL) ? adl_addr[AW-1:0] : addr[AW-1:0];
    assign mem_we   = we_q;
    assign wr_addr  = addr[AW-1:0];
    assign wr_data  = pend_data;
    assign so_o     = so_q;
    assign so_oe_o  = ev.active && out_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_OPC; bitcnt <= '0; shin <= '0; addr <= '0; is_wr <= 1'b0;
            out_sr <= '0; out_on <= 1'b0; wel <= 1'b0; wpen <= 1'b0; bp <= '0;
            busy_cnt <= '0; pend <= 1'b0; pend_data <= '0; we_q <= 1'b0; so_q <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (busy_o) busy_cnt <= busy_cnt - 1'b1;
            if (ev.cs_end) begin
                st <= ST_OPC; bitcnt <= '0; out_on <= 1'b0; pend <= 1'b0;
                if (pend && bitcnt == 3'd0 && wel) begin
                    if (st == ST_WDAT) begin
                        we_q <= 1'b1; wel <= 1'b0; busy_cnt <= BW'(BUSY_CYCLES);
                    end else if (st == ST_SRW && !(wpen && !wp_n_i)) begin
                        wpen <= pend_data[7]; bp <= pend_data[3:2];
                        wel <= 1'b0; busy_cnt <= BW'(BUSY_CYCLES);
                    end
                end
            end else if (ev.rise) begin
                bitcnt <= bitcnt + 1'b1;
                shin   <= rx_byte[6:0];
                if (bitcnt == 3'd7) begin
                    case (st)
                        ST_OPC: begin
                            if (busy_o && rx_byte != OP_RDSR) st <= ST_SKIP;
                            else begin
                                case (rx_byte)
                                    OP_WREN: begin wel <= 1'b1; st <= ST_SKIP; end
                                    OP_WRDI: begin wel <= 1'b0; st <= ST_SKIP; end
                                    OP_RDSR: begin out_sr <= status; out_on <= 1'b1; st <= ST_SRR; end
                                    OP_WRSR: st <= ST_SRW;
                                    OP_READ: begin is_wr <= 1'b0; st <= ST_ADH; end
                                    OP_WRIT: begin is_wr <= 1'b1; st <= ST_ADH; end
                                    default: st <= ST_SKIP;
                                endcase
                            end
                        end
                        ST_ADH: begin addr[15:8] <= rx_byte; st <= ST_ADL; end
                        ST_ADL: begin
                            if (is_wr) begin
                                addr <= adl_addr; st <= ST_WDAT;
                            end else begin
                                addr <= adl_addr + 16'd1; out_sr <= rd_data;
                                out_on <= 1'b1; st <= ST_RDAT;
                            end
                        end
                        ST_RDAT: begin out_sr <= rd_data; addr <= addr + 16'd1; end
                        ST_WDAT, ST_SRW: begin
                            if (!pend) begin pend <= 1'b1; pend_data <= rx_byte; end
                        end
                        ST_SRR: out_sr <= status;
                        default: ;
                    endcase
                end
            end else if (ev.fall) begin
                so_q   <= out_sr[7];
                out_sr <= {out_sr[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
    import eep_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int BUSY_CYCLES = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic si_i,
    input  logic hold_n_i,
    input  logic wp_n_i,
    output logic so_o,
    output logic so_oe_o
);
    localparam int AW = $clog2(DEPTH);

    bus_ev_t       ev;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0]    rd_data, wr_data;
    logic          mem_we, busy;

    eep_bus_front u_front (
        .clk(clk), .rst(rst), .sck_i(sck_i), .cs_n_i(cs_n_i),
        .hold_n_i(hold_n_i), .ev(ev)
    );

    eep_array #(.DEPTH(DEPTH)) u_array (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(rd_data)
    );

    eep_ctrl #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst), .ev(ev), .si_i(si_i), .wp_n_i(wp_n_i),
        .rd_data(rd_data), .rd_addr(rd_addr), .mem_we(mem_we),
        .wr_addr(wr_addr), .wr_data(wr_data), .so_o(so_o),
        .so_oe_o(so_oe_o), .busy_o(busy)
    );
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk (
    input logic clk,
    input logic rst,
    input logic cs_n_i,
    input logic sck_i,
    input logic hold_n_i,
    input logic so_oe_o,
    input logic mem_we,
    input logic busy
);
    AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        cs_n_i |-> !so_oe_o); // R2

    AST_PAUSE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_i && !hold_n_i && !sck_i) |=> !so_oe_o); // R9

    AST_COMMIT_AFTER_DESEL: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(cs_n_i)); // R6

    AST_COMMIT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy); // R7

    AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !$past(busy)); // R7
endmodule

bind spi_eeprom_slave eep_slave_chk u_chk (
    .clk(clk), .rst(rst), .cs_n_i(cs_n_i), .sck_i(sck_i), .hold_n_i(hold_n_i),
    .so_oe_o(so_oe_o), .mem_we(mem_we), .busy(busy)
);

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb;
    localparam int DEPTH = 1024;
    localparam int BUSY = 300;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so_o, so_oe_o;

    int n_chk = 0;
    int n_err = 0;
    bit m3 = 1'b0;
    bit done = 1'b0;

    logic [7:0] model [DEPTH];
    string      q_req [$];
    logic [7:0] q_val [$];
    logic [7:0] rx_val;
    event       rx_ev;

    always #10 clk = ~clk;

    spi_eeprom_slave #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst(rst), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
        .hold_n_i(hold_n), .wp_n_i(wp_n), .so_o(so_o), .so_oe_o(so_oe_o)
    );

    // scoreboard monitor
    initial begin
        forever begin
            @(rx_ev);
            n_chk++;
            if (q_val.size() == 0) begin
                n_err++;
                $display("FAIL scoreboard: byte %02h arrived, expected none", rx_val);
            end else begin
                string r;
                logic [7:0] v;
                r = q_req.pop_front();
                v = q_val.pop_front();
                if (rx_val !== v) begin
                    n_err++;
                    $display("FAIL %s: read %02h expected %02h", r, rx_val, v);
                end
            end
        end
    end

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        sck = 1'b0; si = b; wt(HALF);
        r = so_o;
        sck = 1'b1; wt(HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
    endtask

    task automatic t_begin();
        sck = m3; wt(HALF);
        cs_n = 1'b0; wt(HALF);
    endtask

    task automatic t_end();
        if (!m3) begin sck = 1'b0; wt(HALF); end
        cs_n = 1'b1; wt(2 * HALF);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        t_begin(); xfer(op, d); t_end();
    endtask

    task automatic rdsr_check(input logic [7:0] exp, input string req);
        logic [7:0] d;
        q_req.push_back(req); q_val.push_back(exp);
        t_begin(); xfer(8'h05, d); xfer(8'h00, d);
        rx_val = d; ->rx_ev;
        t_end();
    endtask

    task automatic read_check(input int a, input int n, input string req);
        logic [7:0] d;
        logic [15:0] a16;
        a16 = 16'(a);
        t_begin(); xfer(8'h03, d); xfer(a16[15:8], d); xfer(a16[7:0], d);
        for (int i = 0; i < n; i++) begin
            q_req.push_back(req); q_val.push_back(model[(a + i) % DEPTH]);
            xfer(8'h00, d);
            rx_val = d; ->rx_ev;
        end
        t_end();
    endtask

    task automatic write_seq(input int a, input logic [7:0] v);
        logic [7:0] d;
        logic [15:0] a16;
        a16 = 16'(a);
        t_begin(); xfer(8'h02, d); xfer(a16[15:8], d); xfer(a16[7:0], d); xfer(v, d); t_end();
    endtask

    task automatic wrsr_seq(input logic [7:0] v);
        logic [7:0] d;
        t_begin(); xfer(8'h01, d); xfer(v, d); t_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic b;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;

        // R1 / R11: reset with select already low
        wt(5);
        chk("R1 reset oe", so_oe_o, 1'b0);
        rst = 1'b0; wt(4);
        xfer(8'h06, d);                       // R11: no high-to-low edge yet, WREN ignored
        chk("R11 no drive before select edge", so_oe_o, 1'b0);
        sck = 1'b0; wt(HALF);
        cs_n = 1'b1; wt(2 * HALF);
        rdsr_check(8'h00, "R11 WREN before first select edge ignored");
        rdsr_check(8'h00, "R1 status after reset");
        read_check(5, 1, "R1 array initial FF");

        // R5
        cmd1(8'h06);
        rdsr_check(8'h02, "R5 WREN sets flag");
        cmd1(8'h04);
        rdsr_check(8'h00, "R5 WRDI clears flag");

        // R6 / R7 clean write
        cmd1(8'h06);
        write_seq(16'h0010, 8'hA5);
        model[16'h0010] = 8'hA5;
        rdsr_check(8'h01, "R7 busy after commit, R6 flag cleared");
        wt(BUSY + 20);
        rdsr_check(8'h00, "R7 busy ends");
        read_check(16'h0010, 2, "R4 sequential read");

        // R6 no write without enable
        write_seq(16'h0011, 8'h5A);
        read_check(16'h0011, 1, "R6 write without enable dropped");

        // R6 select rises mid-byte
        cmd1(8'h06);
        t_begin(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h20, d); xfer(8'h3C, d);
        for (int i = 0; i < 3; i++) xbit(1'b1, b);
        t_end();
        rdsr_check(8'h02, "R6 mid-byte end: no commit, flag kept");
        cmd1(8'h04);
        read_check(16'h0020, 1, "R6 mid-byte data not written");

        // R7 opcodes ignored while busy
        cmd1(8'h06);
        write_seq(16'h03FF, 8'h77);
        model[16'h03FF] = 8'h77;
        cmd1(8'h06);
        wt(BUSY + 20);
        rdsr_check(8'h00, "R7 WREN during busy ignored");

        // R4 wrap at end of array
        read_check(DEPTH - 1, 3, "R4 wrap to address 0");

        // R3 mode 3
        m3 = 1'b1;
        read_check(16'h0010, 1, "R3 mode 3 read");
        rdsr_check(8'h00, "R3 mode 3 status");
        m3 = 1'b0;
        sck = 1'b0; wt(HALF);

        // R8 status write and protect input
        cmd1(8'h06);
        wrsr_seq(8'h8C);
        wt(BUSY + 20);
        rdsr_check(8'h8C, "R8 status bits written");
        wp_n = 1'b0;
        cmd1(8'h06);
        wrsr_seq(8'h00);
        wt(BUSY + 20);
        rdsr_check(8'h8E, "R8 refused under protect, flag kept");
        wp_n = 1'b1;
        wrsr_seq(8'h00);
        wt(BUSY + 20);
        rdsr_check(8'h00, "R8 accepted with protect released");

        // R2 clocks with select high
        t_begin(); cs_n = 1'b1; wt(2 * HALF);
        xfer(8'h06, d);
        chk("R2 no drive when deselected", so_oe_o, 1'b0);
        sck = 1'b0; wt(2 * HALF);
        rdsr_check(8'h00, "R2 bits ignored while deselected");

        // R9 pause mid-byte
        begin
            logic [7:0] rb;
            q_req.push_back("R9 byte across pause"); q_val.push_back(model[16'h0010]);
            t_begin(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h10, d);
            for (int i = 7; i >= 4; i--) xbit(1'b0, rb[i]);
            sck = 1'b0; wt(HALF);
            chk("R9 driving before pause", so_oe_o, 1'b1);
            hold_n = 1'b0; wt(HALF);
            chk("R9 no drive in pause", so_oe_o, 1'b0);
            for (int i = 0; i < 3; i++) begin
                si = 1'(i); sck = 1'b1; wt(HALF); sck = 1'b0; wt(HALF);
            end
            chk("R9 no drive while clocked in pause", so_oe_o, 1'b0);
            hold_n = 1'b1; wt(HALF);
            chk("R9 drive after resume", so_oe_o, 1'b1);
            for (int i = 3; i >= 0; i--) xbit(1'b0, rb[i]);
            rx_val = rb; ->rx_ev;
            t_end();
        end

        // R10 select pulse without clocks
        t_begin();
        for (int i = 0; i < 5; i++) xbit(1'b1, b);
        t_end();
        t_begin(); t_end();
        cmd1(8'h06);
        rdsr_check(8'h02, "R10 next byte decoded as opcode");
        cmd1(8'h04);

        wt(20);
        if (q_val.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL scoreboard: %0d reads missing, expected 0", q_val.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule